// File: doc/BRIEF.md
# Two-Operand ALU with Status Flags

This block carries out the two-operand instruction group of a 16-bit microcontroller core. Each cycle it can accept one instruction word together with the source operand, the destination operand and the current arithmetic flags. Operand fetch has already been done. From these it produces the result to store, the new overflow, negative, zero and carry flags, a write-back enable and the number of execution cycles the instruction costs. The cycle count follows from the addressing modes encoded in the word.

Subtraction and compare reuse the adder: the source is inverted within the operand width, and the carry-in is forced to 1 or taken from the current carry. The logical operations that touch the flags use the carry as a "result is nonzero" marker. Compare and bit-test update the flags but never ask for a store. Decimal add and the unused opcode values are reported as errors.

All decoding and datapath logic is combinational. A single registered stage holds the outputs, and a valid strobe marks each accepted instruction.

Top module: `alu2op_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid`, `wb_en`, `op_err`, `result`, `flags_out` and `cycles` are all zero after that edge.
- R2: An instruction presented with `in_valid` high at a rising edge has its outputs visible after that same edge, with `out_valid` high. A cycle with `in_valid` low gives `out_valid`, `wb_en` and `op_err` low after the edge. Back-to-back instructions are accepted every cycle.
- R3: The opcode sits in `insn[15:12]`. ADD (0x5) returns dst+src with carry-in 0. ADDC (0x6) returns dst+src+C, where C is `flags_in[0]`.
- R4: SUB (0x8) and CMP (0x9) add dst, the source inverted within the operand width, and a carry-in of 1. SUBC (0x7) does the same with a carry-in of C.
- R5: The flags are ordered {V,N,Z,C} in bits 3..0. For ADD, ADDC, SUB, SUBC and CMP: Z = masked result is zero; N = result MSB; C = adder bit just above the MSB; V = both addends (source after any inversion) share an MSB and the result MSB differs from it.
- R6: AND (0xF) and BIT (0xB) give dst&src, with V=0, N=result MSB, and exactly one of C (result nonzero) or Z (result zero) set.
- R7: XOR (0xE) gives dst^src. It sets N, Z and C like R6, and sets V only when both operand MSBs are 1.
- R8: MOV (0x4) gives the source, BIC (0xC) gives dst & ~src, and BIS (0xD) gives dst | src. All three return `flags_in` unchanged.
- R9: `wb_en` is high for every valid recognised opcode except CMP and BIT, for which it is low.
- R10: When `insn[6]` is 1 the operation is byte wide. Operands are taken from bits 7..0, result bits 15..8 are zero, and N, C and V come from bits 7 and 8 of the byte operation.
- R11: When the destination is register 0 (the program counter) in register mode (`insn[7]`=0, `insn[3:0]`=0), `cycles` is 2 for a source mode `insn[5:4]` of 0 (register) or 2 (indirect), and 3 for 1 (indexed) or 3 (post-increment).
- R12: For any other destination, the source costs 1 in mode 0, 3 in mode 1 and 2 in modes 2 and 3. An indexed destination (`insn[7]`=1) adds 3.
- R13: Opcodes 0x0 to 0x3 and 0xA set `op_err`, force `wb_en` low and `result` to zero, and return `flags_in` unchanged. `cycles` still follows R11/R12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 16 | Instruction word (opcode, modes, byte flag, registers) |
| src_data | input | 16 | Fetched source operand |
| dst_data | input | 16 | Fetched destination operand |
| flags_in | input | 4 | Current {V,N,Z,C} |
| out_valid | output | 1 | Registered outputs belong to an accepted instruction |
| result | output | 16 | Value to store |
| flags_out | output | 4 | Updated {V,N,Z,C} |
| wb_en | output | 1 | Result must be written to the destination |
| cycles | output | 3 | Execution cycles implied by the addressing modes |
| op_err | output | 1 | Opcode not handled by this block |

## Verification
The adder is driven with patterns chosen to tell the four flags apart. These include plain sums with no flags, an all-ones plus one wrap that sets only Z and C, a signed overflow into the MSB, and equal and reversed operands for SUB and CMP that separate the forced carry-in from a carried-in C. Byte operations carry garbage in the upper operand bytes, so that a wrong lane mask or a flag taken from bit 15 shows up. Every source and destination mode pair, with and without the program counter as destination, pins the cycle table. A long run of mixed opcodes is then compared against an independent model, interleaved with idle cycles that expose any stray `out_valid`.

// File: rtl/alu2op_pkg.sv
// Package alu2op_pkg
// Shared encodings for the two-operand ALU: opcode values, addressing
// modes, decoded operation classes and the packed flag vector.
// Assumes a 16-bit instruction word whose field positions are fixed.
package alu2op_pkg;

    localparam int INSN_W = 16;

    localparam logic [3:0] OPC_MOV  = 4'h4;
    localparam logic [3:0] OPC_ADD  = 4'h5;
    localparam logic [3:0] OPC_ADDC = 4'h6;
    localparam logic [3:0] OPC_SUBC = 4'h7;
    localparam logic [3:0] OPC_SUB  = 4'h8;
    localparam logic [3:0] OPC_CMP  = 4'h9;
    localparam logic [3:0] OPC_BIT  = 4'hB;
    localparam logic [3:0] OPC_BIC  = 4'hC;
    localparam logic [3:0] OPC_BIS  = 4'hD;
    localparam logic [3:0] OPC_XOR  = 4'hE;
    localparam logic [3:0] OPC_AND  = 4'hF;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_IDX = 2'd1,
        SRC_IND = 2'd2,
        SRC_INC = 2'd3
    } src_mode_e;

    typedef enum logic [1:0] {
        CLS_ARITH,      // adder result and adder flags
        CLS_LOGIC_FL,   // logic result, logic flags
        CLS_LOGIC_KEEP, // logic result, flags pass through
        CLS_BAD         // not handled here
    } op_class_e;

    typedef enum logic [1:0] {
        CIN_ZERO,
        CIN_ONE,
        CIN_CARRY
    } cin_sel_e;

    typedef enum logic [2:0] {
        LG_PASS,
        LG_AND,
        LG_XOR,
        LG_BIC,
        LG_BIS
    } logic_op_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu2op_decode.sv
// Module alu2op_decode
// Turns the opcode field and byte flag into control for the datapath:
// operation class, source inversion, carry-in choice, logic function and
// write-back intent. Purely combinational; assumes the opcode values
// from alu2op_pkg.
module alu2op_decode
    import alu2op_pkg::*;
(
    input  logic [3:0] opcode,
    output op_class_e  op_class,
    output logic       inv_src,
    output cin_sel_e   cin_sel,
    output logic_op_e  logic_op,
    output logic       store
);

    // Map each opcode to its datapath controls; unknown codes fall to CLS_BAD.
    always_comb begin
        op_class = CLS_BAD;
        inv_src  = 1'b0;
        cin_sel  = CIN_ZERO;
        logic_op = LG_PASS;
        store    = 1'b0;
        unique case (opcode)
            OPC_MOV: begin
                op_class = CLS_LOGIC_KEEP;
                logic_op = LG_PASS;
                store    = 1'b1;
            end
            OPC_ADD: begin
                op_class = CLS_ARITH;
                cin_sel  = CIN_ZERO;
                store    = 1'b1;
            end
            OPC_ADDC: begin
                op_class = CLS_ARITH;
                cin_sel  = CIN_CARRY;
                store    = 1'b1;
            end
            OPC_SUBC: begin
                op_class = CLS_ARITH;
                inv_src  = 1'b1;
                cin_sel  = CIN_CARRY;
                store    = 1'b1;
            end
            OPC_SUB: begin
                op_class = CLS_ARITH;
                inv_src  = 1'b1;
                cin_sel  = CIN_ONE;
                store    = 1'b1;
            end
            OPC_CMP: begin
                op_class = CLS_ARITH;
                inv_src  = 1'b1;
                cin_sel  = CIN_ONE;
                store    = 1'b0;
            end
            OPC_BIT: begin
                op_class = CLS_LOGIC_FL;
                logic_op = LG_AND;
                store    = 1'b0;
            end
            OPC_BIC: begin
                op_class = CLS_LOGIC_KEEP;
                logic_op = LG_BIC;
                store    = 1'b1;
            end
            OPC_BIS: begin
                op_class = CLS_LOGIC_KEEP;
                logic_op = LG_BIS;
                store    = 1'b1;
            end
            OPC_XOR: begin
                op_class = CLS_LOGIC_FL;
                logic_op = LG_XOR;
                store    = 1'b1;
            end
            OPC_AND: begin
                op_class = CLS_LOGIC_FL;
                logic_op = LG_AND;
                store    = 1'b1;
            end
            default: begin
                op_class = CLS_BAD;
                store    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu2op_cycles.sv
// Module alu2op_cycles
// Computes the execution cycle count from the source mode, destination
// mode and destination register. Assumes the program counter is register
// PC_REG and that CYC_W bits hold the largest count (6).
module alu2op_cycles
    import alu2op_pkg::*;
#(
    parameter int CYC_W  = 3,
    parameter int REG_W  = 4,
    parameter int PC_REG = 0
) (
    input  src_mode_e        src_mode,
    input  logic             dst_indexed,
    input  logic [REG_W-1:0] dst_reg,
    output logic [CYC_W-1:0] cycles
);

    localparam logic [CYC_W-1:0] C_ONE   = CYC_W'(1);
    localparam logic [CYC_W-1:0] C_TWO   = CYC_W'(2);
    localparam logic [CYC_W-1:0] C_THREE = CYC_W'(3);

    logic             pc_dest;
    logic [CYC_W-1:0] src_cost;

    // A jump-like move: PC written in register mode.
    assign pc_dest = !dst_indexed && (dst_reg == REG_W'(PC_REG));

    // Select the base cost for the source mode in both tables.
    always_comb begin
        if (pc_dest) begin
            unique case (src_mode)
                SRC_REG, SRC_IND: src_cost = C_TWO;
                default:          src_cost = C_THREE;
            endcase
        end else begin
            unique case (src_mode)
                SRC_REG: src_cost = C_ONE;
                SRC_IDX: src_cost = C_THREE;
                default: src_cost = C_TWO;
            endcase
        end
    end

    // Indexed destination costs three more cycles.
    assign cycles = dst_indexed ? (src_cost + C_THREE) : src_cost;

endmodule

// File: rtl/alu2op_arith.sv
// Module alu2op_arith
// Width-selectable adder for add, add-with-carry, subtract and compare.
// Subtraction is an add of the inverted source with a carry-in chosen by
// the caller. Produces the masked result and V/N/Z/C. Assumes DATA_W is
// even and the byte lane is the lower half.
module alu2op_arith
    import alu2op_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic              inv_src,
    input  logic              carry_in,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] sum_out,
    output flags_t            sum_flags
);

    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    logic [DATA_W:0]   sum_full;
    logic              a_msb;
    logic              b_msb;
    logic              r_msb;
    logic              carry_out;

    // Build the operand mask bit by bit: the upper half follows byte_mode.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        if (gi < BYTE_W) begin : g_lo
            assign lane_mask[gi] = 1'b1;
        end else begin : g_hi
            assign lane_mask[gi] = ~byte_mode;
        end
    end

    // Mask both addends, inverting the source inside the active width.
    assign a_m = dst_val & lane_mask;
    assign b_m = (inv_src ? ~src_val : src_val) & lane_mask;

    // One wide add with the carry-in.
    assign sum_full = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, carry_in};
    assign sum_out  = sum_full[DATA_W-1:0] & lane_mask;

    // Pick sign and carry positions for the active width.
    assign a_msb     = byte_mode ? a_m[BYTE_W-1] : a_m[DATA_W-1];
    assign b_msb     = byte_mode ? b_m[BYTE_W-1] : b_m[DATA_W-1];
    assign r_msb     = byte_mode ? sum_out[BYTE_W-1] : sum_out[DATA_W-1];
    assign carry_out = byte_mode ? sum_full[BYTE_W] : sum_full[DATA_W];

    // Assemble the flag vector.
    always_comb begin
        sum_flags.v = (a_msb == b_msb) && (r_msb != a_msb);
        sum_flags.n = r_msb;
        sum_flags.z = (sum_out == '0);
        sum_flags.c = carry_out;
    end

endmodule

// File: rtl/alu2op_logic.sv
// Module alu2op_logic
// Bitwise unit for move, and, xor, bit-clear and bit-set. Flags follow the
// test convention: C marks a nonzero result, Z a zero one, N the MSB, V
// only for xor with both operand MSBs set. Assumes DATA_W is even.
module alu2op_logic
    import alu2op_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic_op_e         logic_op,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] lg_out,
    output flags_t            lg_flags
);

    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    logic [DATA_W-1:0] raw;
    logic              a_msb;
    logic              b_msb;
    logic              r_msb;

    // Per-bit lane mask, upper half disabled in byte mode.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        if (gi < BYTE_W) begin : g_lo
            assign lane_mask[gi] = 1'b1;
        end else begin : g_hi
            assign lane_mask[gi] = ~byte_mode;
        end
    end

    assign a_m = dst_val & lane_mask;
    assign b_m = src_val & lane_mask;

    // Apply the selected bitwise function.
    always_comb begin
        unique case (logic_op)
            LG_AND:  raw = a_m & b_m;
            LG_XOR:  raw = a_m ^ b_m;
            LG_BIC:  raw = a_m & ~b_m;
            LG_BIS:  raw = a_m | b_m;
            default: raw = b_m;
        endcase
    end

    assign lg_out = raw & lane_mask;
    assign a_msb  = byte_mode ? a_m[BYTE_W-1] : a_m[DATA_W-1];
    assign b_msb  = byte_mode ? b_m[BYTE_W-1] : b_m[DATA_W-1];
    assign r_msb  = byte_mode ? lg_out[BYTE_W-1] : lg_out[DATA_W-1];

    // Test-style flags; the caller decides whether they are used.
    always_comb begin
        lg_flags.v = (logic_op == LG_XOR) && a_msb && b_msb;
        lg_flags.n = r_msb;
        lg_flags.z = (lg_out == '0);
        lg_flags.c = (lg_out != '0);
    end

endmodule

// File: rtl/alu2op_core.sv
// Module alu2op_core (top)
// Executes one two-operand instruction per accepted cycle: decodes the
// word, runs the adder or the logic unit, merges flags and registers
// result, flags, write-back enable, cycle count and error in one stage.
// Assumes operands are already fetched; reset is synchronous, active low.
module alu2op_core
    import alu2op_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CYC_W  = 3,
    parameter int PC_REG = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       insn,
    input  logic [DATA_W-1:0] src_data,
    input  logic [DATA_W-1:0] dst_data,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags_out,
    output logic              wb_en,
    output logic [CYC_W-1:0]  cycles,
    output logic              op_err
);

    localparam int REG_W = 4;

    logic [3:0]        f_opcode;
    logic [REG_W-1:0]  f_dst_reg;
    logic              f_dst_idx;
    logic              f_byte;
    src_mode_e         f_src_mode;
    logic              unused_src_reg;

    op_class_e         op_class;
    logic              inv_src;
    cin_sel_e          cin_sel;
    logic_op_e         logic_op;
    logic              store;
    logic              carry_in;
    flags_t            cur_flags;

    logic [DATA_W-1:0] sum_val;
    flags_t            sum_flags;
    logic [DATA_W-1:0] lg_val;
    flags_t            lg_flags;
    logic [CYC_W-1:0]  cyc_nx;

    logic [DATA_W-1:0] res_nx;
    flags_t            flags_nx;

    // Split the instruction word into its fields.
    assign f_opcode       = insn[15:12];
    assign f_dst_idx      = insn[7];
    assign f_byte         = insn[6];
    assign f_src_mode     = src_mode_e'(insn[5:4]);
    assign f_dst_reg      = insn[3:0];
    assign unused_src_reg = ^insn[11:8];
    assign cur_flags      = flags_t'(flags_in);

    alu2op_decode u_dec (
        .opcode   (f_opcode),
        .op_class (op_class),
        .inv_src  (inv_src),
        .cin_sel  (cin_sel),
        .logic_op (logic_op),
        .store    (store)
    );

    // Choose the adder carry-in.
    always_comb begin
        unique case (cin_sel)
            CIN_ONE:   carry_in = 1'b1;
            CIN_CARRY: carry_in = cur_flags.c;
            default:   carry_in = 1'b0;
        endcase
    end

    alu2op_arith #(.DATA_W(DATA_W)) u_arith (
        .dst_val   (dst_data),
        .src_val   (src_data),
        .inv_src   (inv_src),
        .carry_in  (carry_in),
        .byte_mode (f_byte),
        .sum_out   (sum_val),
        .sum_flags (sum_flags)
    );

    alu2op_logic #(.DATA_W(DATA_W)) u_logic (
        .dst_val   (dst_data),
        .src_val   (src_data),
        .logic_op  (logic_op),
        .byte_mode (f_byte),
        .lg_out    (lg_val),
        .lg_flags  (lg_flags)
    );

    alu2op_cycles #(.CYC_W(CYC_W), .REG_W(REG_W), .PC_REG(PC_REG)) u_cyc (
        .src_mode    (f_src_mode),
        .dst_indexed (f_dst_idx),
        .dst_reg     (f_dst_reg),
        .cycles      (cyc_nx)
    );

    // Merge unit outputs according to the operation class.
    always_comb begin
        unique case (op_class)
            CLS_ARITH: begin
                res_nx   = sum_val;
                flags_nx = sum_flags;
            end
            CLS_LOGIC_FL: begin
                res_nx   = lg_val;
                flags_nx = lg_flags;
            end
            CLS_LOGIC_KEEP: begin
                res_nx   = lg_val;
                flags_nx = cur_flags;
            end
            default: begin
                res_nx   = '0;
                flags_nx = cur_flags;
            end
        endcase
    end

    // Output register stage with valid-qualified strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_out <= '0;
            wb_en     <= 1'b0;
            cycles    <= '0;
            op_err    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wb_en     <= in_valid && store;
            op_err    <= in_valid && (op_class == CLS_BAD);
            if (in_valid) begin
                result    <= res_nx;
                flags_out <= flags_nx;
                cycles    <= cyc_nx;
            end
        end
    end

endmodule

// File: rtl/alu2op_chk.sv
// Module alu2op_chk
// Property checker bound to alu2op_core. Watches the port-level timing
// and encoding rules; drives nothing. Assumes the default opcode map.
module alu2op_chk #(
    parameter int DATA_W = 16,
    parameter int CYC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [15:0]       insn,
    input logic [3:0]        flags_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        flags_out,
    input logic              wb_en,
    input logic [CYC_W-1:0]  cycles,
    input logic              op_err
);

    localparam int BYTE_W = DATA_W / 2;

    logic [3:0] opc;
    logic       opc_bad;
    logic       opc_keep;
    logic       opc_test;

    assign opc      = insn[15:12];
    assign opc_bad  = (opc < 4'h4) || (opc == 4'hA);
    assign opc_keep = (opc == 4'h4) || (opc == 4'hC) || (opc == 4'hD);
    assign opc_test = (opc == 4'hB) || (opc == 4'hF) || (opc == 4'hE);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !wb_en && !op_err && flags_out == 4'h0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en && !op_err));

    a_r9_no_store_cmp_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opc == 4'h9 || opc == 4'hB)) |=> !wb_en);

    a_r13_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc_bad) |=> (op_err && !wb_en && flags_out == $past(flags_in)));

    a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc_keep) |=> (flags_out == $past(flags_in)));

    a_r6_zc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc_test) |=> (flags_out[1] != flags_out[0]));

    a_r10_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[6]) |=> (result[DATA_W-1:BYTE_W] == '0));

    a_r12_cycles_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cycles >= CYC_W'(1) && cycles <= CYC_W'(6)));

endmodule

bind alu2op_core alu2op_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .insn      (insn),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out),
    .wb_en     (wb_en),
    .cycles    (cycles),
    .op_err    (op_err)
);

// File: tb/tb_alu2op_core.sv
// Scoreboard bench for alu2op_core: the driver pushes model predictions
// into a queue, the monitor pops one per out_valid and compares.
module tb_alu2op_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] insn = '0;
    logic [15:0] src_data = '0;
    logic [15:0] dst_data = '0;
    logic [3:0]  flags_in = '0;
    logic        out_valid;
    logic [15:0] result;
    logic [3:0]  flags_out;
    logic        wb_en;
    logic [2:0]  cycles;
    logic        op_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [15:0] res;
        logic [3:0]  fl;
        logic        wb;
        logic [2:0]  cyc;
        logic        err;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    alu2op_core dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .src_data(src_data), .dst_data(dst_data), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .flags_out(flags_out),
        .wb_en(wb_en), .cycles(cycles), .op_err(op_err)
    );

    function automatic logic [15:0] mk(input logic [3:0] op, input logic dm,
                                       input logic byt, input logic [1:0] sm,
                                       input logic [3:0] dreg);
        return {op, 4'h7, dm, byt, sm, dreg};
    endfunction

    // Independent reference model written from the requirements.
    function automatic exp_t model(input logic [15:0] w, input logic [15:0] s_in,
                                   input logic [15:0] d_in, input logic [3:0] fi);
        exp_t e;
        int   msb;
        logic [15:0] mask, s, d, sv, r;
        logic [31:0] sum;
        logic cin;
        logic [3:0] op;
        op   = w[15:12];
        mask = w[6] ? 16'h00FF : 16'hFFFF;
        msb  = w[6] ? 7 : 15;
        s = s_in & mask;
        d = d_in & mask;
        e.err = 1'b0; e.wb = 1'b1; e.fl = fi; e.res = '0; e.tag = "";
        case (op)
            4'h4: e.res = s;
            4'h5, 4'h6, 4'h7, 4'h8, 4'h9: begin
                sv  = (op >= 4'h7) ? (~s & mask) : s;
                cin = (op == 4'h5) ? 1'b0 : ((op == 4'h6 || op == 4'h7) ? fi[0] : 1'b1);
                sum = 32'(d) + 32'(sv) + 32'(cin);
                r   = sum[15:0] & mask;
                e.res = r;
                e.fl  = {(d[msb] == sv[msb]) && (r[msb] != d[msb]), r[msb], r == 0, sum[msb+1]};
                e.wb  = (op != 4'h9);
            end
            4'hB, 4'hF: begin
                r = s & d; e.res = r;
                e.fl = {1'b0, r[msb], r == 0, r != 0};
                e.wb = (op == 4'hF);
            end
            4'hE: begin
                r = s ^ d; e.res = r;
                e.fl = {s[msb] & d[msb], r[msb], r == 0, r != 0};
            end
            4'hC: e.res = d & ~s;
            4'hD: e.res = d | s;
            default: begin e.err = 1'b1; e.wb = 1'b0; end
        endcase
        if (!w[7] && w[3:0] == 4'h0)
            e.cyc = (w[5:4] == 2'd0 || w[5:4] == 2'd2) ? 3'd2 : 3'd3;
        else
            e.cyc = ((w[5:4] == 2'd0) ? 3'd1 : (w[5:4] == 2'd1) ? 3'd3 : 3'd2) + (w[7] ? 3'd3 : 3'd0);
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: present one instruction for one cycle and queue its prediction.
    task automatic send(input logic [15:0] w, input logic [15:0] s, input logic [15:0] d,
                        input logic [3:0] fi, input string tag);
        exp_t e;
        e = model(w, s, d, fi);
        e.tag = tag;
        sb_q.push_back(e);
        insn = w; src_data = s; dst_data = d; flags_in = fi; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every out_valid pops one prediction and compares all fields.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected out_valid", 32'(out_valid), 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(result == e.res,   e.tag, "result", 32'(result), 32'(e.res));
                check(flags_out == e.fl, e.tag, "flags",  32'(flags_out), 32'(e.fl));
                check(wb_en == e.wb,     e.tag, "wb_en",  32'(wb_en), 32'(e.wb));
                check(cycles == e.cyc,   e.tag, "cycles", 32'(cycles), 32'(e.cyc));
                check(op_err == e.err,   e.tag, "op_err", 32'(op_err), 32'(e.err));
            end
        end else if (rst_n) begin
            check(!wb_en && !op_err, "R2", "strobes while idle", 32'({wb_en, op_err}), 32'd0);
        end
    end

    initial begin
        // R1: reset with in_valid asserted must still leave outputs at zero.
        in_valid = 1'b1; insn = mk(4'h5, 1'b0, 1'b0, 2'd0, 4'h5);
        src_data = 16'h1111; dst_data = 16'h2222;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
        check(result == 16'h0 && flags_out == 4'h0, "R1", "result/flags in reset",
              32'({result, flags_out}), 32'd0);
        check(wb_en == 1'b0 && op_err == 1'b0 && cycles == 3'd0, "R1", "strobes in reset",
              32'({wb_en, op_err, cycles}), 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);
        check(out_valid == 1'b0, "R2", "idle after reset", 32'(out_valid), 32'd0);

        // R3: add and add-with-carry.
        send(mk(4'h5, 0, 0, 2'd0, 4'h5), 16'h0FF0, 16'h1234, 4'h0, "R3 add plain");
        send(mk(4'h5, 0, 0, 2'd0, 4'h5), 16'h0001, 16'hFFFF, 4'h0, "R3 add wrap");
        send(mk(4'h6, 0, 0, 2'd0, 4'h5), 16'h0000, 16'h7FFF, 4'h1, "R3 addc carry in");
        send(mk(4'h6, 0, 0, 2'd0, 4'h5), 16'h0003, 16'h0004, 4'h0, "R3 addc no carry");
        // R4: subtract, compare and subtract-with-carry.
        send(mk(4'h8, 0, 0, 2'd0, 4'h5), 16'h0003, 16'h0005, 4'h0, "R4 sub positive");
        send(mk(4'h8, 0, 0, 2'd0, 4'h5), 16'h0005, 16'h0003, 4'h0, "R4 sub borrow");
        send(mk(4'h9, 0, 0, 2'd0, 4'h5), 16'hA5A5, 16'hA5A5, 4'h0, "R4 R9 cmp equal");
        send(mk(4'h7, 0, 0, 2'd0, 4'h5), 16'h0003, 16'h0005, 4'h0, "R4 subc C=0");
        send(mk(4'h7, 0, 0, 2'd0, 4'h5), 16'h0003, 16'h0005, 4'h1, "R4 subc C=1");
        // R5: signed overflow cases.
        send(mk(4'h5, 0, 0, 2'd0, 4'h5), 16'h8000, 16'h8000, 4'h0, "R5 add neg overflow");
        send(mk(4'h8, 0, 0, 2'd0, 4'h5), 16'h0001, 16'h8000, 4'h0, "R5 sub overflow");
        // R6/R7: test-style flags.
        send(mk(4'hF, 0, 0, 2'd0, 4'h5), 16'h0F0F, 16'hF0F0, 4'hF, "R6 and zero");
        send(mk(4'hB, 0, 0, 2'd0, 4'h5), 16'h8000, 16'h8001, 4'h0, "R6 R9 bit msb");
        send(mk(4'hE, 0, 0, 2'd0, 4'h5), 16'h8001, 16'h8000, 4'h0, "R7 xor both msb");
        send(mk(4'hE, 0, 0, 2'd0, 4'h5), 16'h1234, 16'h1234, 4'h0, "R7 xor zero");
        // R8: flag-preserving moves.
        send(mk(4'h4, 0, 0, 2'd0, 4'h5), 16'hBEEF, 16'h1111, 4'hA, "R8 mov");
        send(mk(4'hC, 0, 0, 2'd0, 4'h5), 16'h00F0, 16'hFFFF, 4'h5, "R8 bic");
        send(mk(4'hD, 0, 0, 2'd0, 4'h5), 16'h0F00, 16'h00F0, 4'h3, "R8 bis");
        // R10: byte mode with garbage in upper bytes.
        send(mk(4'h5, 0, 1, 2'd0, 4'h5), 16'hAB01, 16'hCDFF, 4'h0, "R10 byte add wrap");
        send(mk(4'h4, 0, 1, 2'd0, 4'h5), 16'h1234, 16'hFFFF, 4'h0, "R10 byte mov");
        send(mk(4'h5, 0, 1, 2'd0, 4'h5), 16'hFF40, 16'h0040, 4'h0, "R10 byte overflow");
        send(mk(4'hE, 0, 1, 2'd0, 4'h5), 16'h0081, 16'h7F80, 4'h0, "R10 byte xor");
        idle(1);
        check(out_valid == 1'b0, "R2", "gap clears valid", 32'(out_valid), 32'd0);
        // R11/R12: every mode pair.
        for (int sm = 0; sm < 4; sm++) begin
            send(mk(4'h4, 0, 0, 2'(sm), 4'h0), 16'h0100, 16'h0, 4'h0, "R11 pc dest");
            send(mk(4'h4, 0, 0, 2'(sm), 4'h6), 16'h0100, 16'h0, 4'h0, "R12 reg dest");
            send(mk(4'h5, 1, 0, 2'(sm), 4'h0), 16'h0100, 16'h0, 4'h0, "R12 indexed dest");
        end
        // R13: unhandled opcodes.
        send(mk(4'h2, 0, 0, 2'd1, 4'h5), 16'h1234, 16'h4321, 4'h9, "R13 opcode 2");
        send(mk(4'hA, 1, 0, 2'd0, 4'h5), 16'h1234, 16'h4321, 4'h6, "R13 decimal add");
        send(mk(4'h0, 0, 0, 2'd0, 4'h0), 16'h1234, 16'h4321, 4'hF, "R13 opcode 0");
        // R2/R3..R13: mixed stream with random gaps against the model.
        for (int k = 0; k < 400; k++) begin
            send($urandom(), $urandom(), $urandom(), 4'($urandom()), "R2 mixed");
            if (($urandom() & 3) == 0) idle(1);
        end
        idle(3);
        check(sb_q.size() == 0, "R2", "all predictions consumed", 32'(sb_q.size()), 32'd0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule